// File: doc/BRIEF.md
# FIFO-Buffered Serial Peripheral Master

This block is a memory-mapped SPI master. Software talks to it over a simple 32-bit register bus. A data port pushes words into a four-entry transmit queue and pops words from a four-entry receive queue. The block sends 8-bit or 16-bit words on a serial clock that is derived from the base clock by a programmable divider. Clock polarity, clock phase and bit order can all be selected. Chip selects are not part of the block; software drives them from general-purpose outputs.

The block has two operating modes. In configuration mode software sets the divider, the word length, polarity, phase and bit order, and it may preload words. In active mode the block shifts every queued word out and places the word it receives in exchange into the receive queue. A threshold on the receive fill raises an interrupt, so software can collect a burst of words at once.

Top module: `spim_top`

## Requirements
- R1: After reset the block is in configuration mode (register 0x00 reads 0x40), both queues are empty, status (0x14) reads 0x8004, control 1 (0x08) reads 0x0108, `irq` is 0 and `sclk` is 0.
- R2: Each write to the data port 0x18 pushes bits 15:0 into the transmit queue. A write to a full queue (4 words) is dropped. Status bits 13:11 give the transmit fill, and status bit 15 is set while the transmit queue is empty.
- R3: A word starts shifting only when the mode field (0x00 bits 7:6) is 2'b10 (active), the stop bit (0x00 bit 1) is clear and the transmit queue is not empty. In configuration mode (2'b01) queued words stay queued.
- R4: Every word sent yields exactly one received word, which is pushed into the receive queue. Status bits 10:8 give the receive fill. A read of 0x18 pops the oldest word into bits 15:0. No new word starts while the receive queue is full.
- R5: The serial clock period is (n+1) base-clock cycles, where n is 0x08 bits 15:8. A write of 0 is stored as 1.
- R6: In 0x08 bits 7:0, a word-length value of 16 selects 16-bit words and any other value selects 8-bit words. The field reads back as 16 or 8.
- R7: 0x04 bit 0 sets the idle level of `sclk`. 0x04 bit 1 set means data is sampled on the trailing edge of each bit; clear means it is sampled on the leading edge.
- R8: 0x04 bit 2 clear sends the most significant bit first; set sends the least significant bit first. Received words use the same order.
- R9: Writes to the divider, word length, polarity, phase and bit-order fields are ignored unless the mode field is 2'b01.
- R10: 0x04 bits 13:12 hold the receive level minus one. Status bit 14 is set while the receive fill is at or above that level. `irq` equals that flag ANDed with 0x04 bit 9. Both of these fields are writable in any mode.
- R11: Writing 0x00 with bit 0 set empties both queues.
- R12: While the stop bit is set, no new word starts, even in active mode.
- R13: Status bit 2 is set only when no word is shifting and the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Receive-threshold interrupt |

## Verification
The bench loops `mosi` back to `miso`, so every received word must match the word sent. It also decodes the serial line on the sampling edge that phase and polarity select, which means that swapping the bit order, the sample edge or the word length shows up as wrong serial words even where the loopback would hide it. The timing of the sample edges is checked against the divider: an off-by-one divider gives a period one cycle short or long. Directed cases fill the transmit queue past four, stall on a full receive queue, hold the stop bit, clear the queues and write locked fields in active mode. A design that drops the back-pressure would lose words, and one that lets locked writes through would read back the new divider.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DIV_W = 8;
  localparam logic [4:0] ADDR_MODE = 5'h00;
  localparam logic [4:0] ADDR_CTL0 = 5'h04;
  localparam logic [4:0] ADDR_CTL1 = 5'h08;
  localparam logic [4:0] ADDR_STAT = 5'h14;
  localparam logic [4:0] ADDR_DATA = 5'h18;
  localparam logic [1:0] MODE_CFG = 2'b01;
  localparam logic [1:0] MODE_RUN = 2'b10;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic             txPush;
    logic             rxPop;
    logic             clearAll;
    logic             runEn;
    logic             cpol;
    logic             cpha;
    logic             lsbFirst;
    logic             wide;
    logic [DIV_W-1:0] div;
  } spimCmd_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 4,
  parameter int W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush = push && (count != CNT_W'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop) count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimCmd_t          cmd,
  input  logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxHead,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic [WORD_W-1:0] txHead, txSh, rxSh, rxShNext, rxWord, loadWord;
  logic [DIV_W-1:0] cnt, curDiv;
  logic [3:0] bitIdx, lastIdx;
  logic curCpol, curCpha, curLsb, curWide;
  logic startNow, leadNow, trailNow, sampleNow, shiftNow, doneNow;

  spim_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_txq (
    .clk(clk), .rstN(rstN), .clear(cmd.clearAll), .push(cmd.txPush),
    .pop(startNow), .din(txWord), .dout(txHead), .count(txCount));

  spim_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_rxq (
    .clk(clk), .rstN(rstN), .clear(cmd.clearAll), .push(doneNow),
    .pop(cmd.rxPop), .din(rxWord), .dout(rxHead), .count(rxCount));

  assign startNow  = !busy && cmd.runEn && (txCount != '0) && (rxCount != CNT_W'(DEPTH));
  assign leadNow   = busy && (cnt == (curDiv >> 1));
  assign trailNow  = busy && (cnt == curDiv);
  assign lastIdx   = curWide ? 4'd15 : 4'd7;
  assign sampleNow = curCpha ? trailNow : leadNow;
  assign shiftNow  = curCpha ? (leadNow && bitIdx != '0) : (trailNow && bitIdx != lastIdx);
  assign doneNow   = trailNow && (bitIdx == lastIdx);

  assign rxShNext = !sampleNow ? rxSh :
                    curLsb ? {miso, rxSh[WORD_W-1:1]} : {rxSh[WORD_W-2:0], miso};
  assign rxWord   = curWide ? rxShNext :
                    curLsb ? {8'h00, rxShNext[15:8]} : {8'h00, rxShNext[7:0]};
  assign loadWord = (cmd.lsbFirst || cmd.wide) ? txHead : {txHead[7:0], 8'h00};
  assign mosi     = curLsb ? txSh[0] : txSh[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt <= '0;
      bitIdx <= '0;
      txSh <= '0;
      rxSh <= '0;
      sclk <= 1'b0;
      curDiv <= DIV_W'(1);
      {curCpol, curCpha, curLsb, curWide} <= '0;
    end else begin
      rxSh <= rxShNext;
      if (startNow) begin
        busy <= 1'b1;
        cnt <= '0;
        bitIdx <= '0;
        txSh <= loadWord;
        rxSh <= '0;
        curDiv <= cmd.div;
        {curCpol, curCpha, curLsb, curWide} <= {cmd.cpol, cmd.cpha, cmd.lsbFirst, cmd.wide};
      end else if (busy) begin
        cnt <= trailNow ? '0 : cnt + 1'b1;
        if (leadNow) sclk <= ~curCpol;
        if (trailNow) begin
          sclk <= curCpol;
          bitIdx <= bitIdx + 1'b1;
        end
        if (shiftNow) txSh <= curLsb ? (txSh >> 1) : (txSh << 1);
        if (doneNow) busy <= 1'b0;
      end else begin
        sclk <= cmd.cpol;
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LVL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [4:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             busy,
  input  logic [15:0]      rxHead,
  output spimCmd_t         cmd,
  output logic             irq
);
  logic [1:0] modeQ;
  logic stopQ, cpolQ, cphaQ, lsbQ, wideQ, irqEnQ;
  logic [LVL_W-1:0] lvlM1Q;
  logic [DIV_W-1:0] divQ;
  logic wrEn, cfgOpen, rxFlag, idle;
  logic unusedHiBits;

  assign unusedHiBits = ^busWdata[31:16];
  assign wrEn    = busSel && busWr;
  assign cfgOpen = (modeQ == MODE_CFG);
  assign rxFlag  = rxCount >= (CNT_W'(lvlM1Q) + CNT_W'(1));
  assign idle    = !busy && (txCount == '0);
  assign irq     = rxFlag && irqEnQ;

  always_comb begin
    cmd.txPush   = wrEn && (busAddr == ADDR_DATA);
    cmd.rxPop    = busSel && !busWr && (busAddr == ADDR_DATA);
    cmd.clearAll = wrEn && (busAddr == ADDR_MODE) && busWdata[0];
    cmd.runEn    = (modeQ == MODE_RUN) && !stopQ;
    cmd.cpol     = cpolQ;
    cmd.cpha     = cphaQ;
    cmd.lsbFirst = lsbQ;
    cmd.wide     = wideQ;
    cmd.div      = divQ;
  end

  always_comb begin
    case (busAddr)
      ADDR_MODE: busRdata = {24'h0, modeQ, 4'h0, stopQ, 1'b0};
      ADDR_CTL0: busRdata = {18'h0, 2'(lvlM1Q), 2'b0, irqEnQ, 6'h0, lsbQ, cphaQ, cpolQ};
      ADDR_CTL1: busRdata = {16'h0, divQ, wideQ ? 8'd16 : 8'd8};
      ADDR_STAT: busRdata = {16'h0, txCount == '0, rxFlag, 3'(txCount), 3'(rxCount),
                             5'h0, idle, 2'b0};
      ADDR_DATA: busRdata = {16'h0, rxHead};
      default:   busRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_CFG;
      stopQ <= 1'b0;
      {cpolQ, cphaQ, lsbQ, wideQ, irqEnQ} <= '0;
      lvlM1Q <= '0;
      divQ <= DIV_W'(1);
    end else if (wrEn) begin
      case (busAddr)
        ADDR_MODE: begin
          modeQ <= busWdata[7:6];
          stopQ <= busWdata[1];
        end
        ADDR_CTL0: begin
          irqEnQ <= busWdata[9];
          lvlM1Q <= busWdata[12 +: LVL_W];
          if (cfgOpen) {lsbQ, cphaQ, cpolQ} <= busWdata[2:0];
        end
        ADDR_CTL1: begin
          if (cfgOpen) begin
            divQ  <= (busWdata[15:8] == '0) ? DIV_W'(1) : busWdata[8 +: DIV_W];
            wideQ <= (busWdata[7:0] == 8'd16);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  spimCmd_t cmd;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [15:0] rxHead;
  logic busy;

  spim_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txCount(txCount), .rxCount(rxCount),
    .busy(busy), .rxHead(rxHead), .cmd(cmd), .irq(irq));

  spim_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txWord(busWdata[15:0]), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount), .busy(busy), .sclk(sclk), .mosi(mosi),
    .miso(miso));
endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input spimCmd_t         cmd,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic             busy,
  input logic             sclk,
  input logic             irq
);
  // R2 / R4: queue fills never exceed the depth
  assert_fifo_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CNT_W'(DEPTH)) && (rxCount <= CNT_W'(DEPTH)));

  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmd.runEn && (txCount != '0)));

  assert_rx_room_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(rxCount) != CNT_W'(DEPTH)));

  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.runEn |=> ($stable(cmd.div) && $stable(cmd.wide) && $stable(cmd.cpol)
                   && $stable(cmd.cpha) && $stable(cmd.lsbFirst)));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> (sclk == $past(cmd.cpol)));

  assert_irq_needs_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rxCount != '0));
endmodule

bind spim_top spim_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .txCount(txCount), .rxCount(rxCount),
  .busy(busy), .sclk(sclk), .irq(irq));

// File: tb/spim_top_tb.sv
`timescale 1ns/1ps
module spim_top_tb;
  logic clk = 1'b0, rstN = 1'b0, busSel = 1'b0, busWr = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  wire [31:0] busRdata;
  wire sclk, mosi, irq;
  wire miso = mosi;
  int checks = 0, errors = 0;

  spim_top u_dut (.clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .irq(irq));

  always #10 clk = ~clk;

  // serial line monitor
  logic monEn = 1'b0, monCpol = 1'b0, monCpha = 1'b0, monLsb = 1'b0, monWide = 1'b0;
  int monDiv = 1, bitN = 0, perErr = 0;
  logic [15:0] acc = '0;
  logic [15:0] cap [$];
  time lastT = 0;

  always @(sclk) begin
    if (monEn && (sclk == (monCpha ? monCpol : !monCpol))) begin
      if (bitN > 0 && ($time - lastT) != time'((monDiv + 1) * 20)) perErr++;
      lastT = $time;
      if (monLsb) acc[bitN] = mosi;
      else acc = {acc[14:0], mosi};
      bitN++;
      if (bitN == (monWide ? 16 : 8)) begin
        cap.push_back(monWide ? acc : {8'h00, acc[7:0]});
        bitN = 0;
        acc = '0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] st;
    do busRead(5'h14, st); while (!st[2]);
  endtask

  function automatic logic [31:0] txFill(input logic [31:0] st);
    return (st >> 11) & 32'h7;
  endfunction
  function automatic logic [31:0] rxFill(input logic [31:0] st);
    return (st >> 8) & 32'h7;
  endfunction
  function automatic logic [15:0] expWord(input logic [15:0] w, input logic wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  task automatic setCfg(input int dv, input logic wide, input logic cpol,
                        input logic cpha, input logic lsb, input logic [31:0] irqBits);
    monEn = 1'b0;
    busWrite(5'h00, 32'h40);
    busWrite(5'h04, irqBits | {29'h0, lsb, cpha, cpol});
    busWrite(5'h08, (dv << 8) | (wide ? 32'd16 : 32'd8));
    repeat (2) @(posedge clk);
    monDiv = dv; monWide = wide; monCpol = cpol; monCpha = cpha; monLsb = lsb;
    bitN = 0; acc = '0; perErr = 0; cap.delete();
    #1 monEn = 1'b1;
  endtask

  task automatic runBatch(input string tag, input int n, input logic [15:0] w [4]);
    logic [31:0] d;
    for (int i = 0; i < n; i++) busWrite(5'h18, {16'h0, w[i]});
    busWrite(5'h00, 32'h80);
    waitIdle();
    busRead(5'h14, d);
    check({tag, " R4 rx fill"}, rxFill(d), n);
    for (int i = 0; i < n; i++) begin
      busRead(5'h18, d);
      check({tag, " R4 rx word"}, d, {16'h0, expWord(w[i], monWide)});
      check({tag, " R8 serial word"}, (i < cap.size()) ? {16'h0, cap[i]} : 32'hdead,
            {16'h0, expWord(w[i], monWide)});
    end
    check({tag, " R5 sclk period"}, perErr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] w [4];
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    busRead(5'h14, d); check("R1 status", d, 32'h8004);
    busRead(5'h00, d); check("R1 mode", d, 32'h40);
    busRead(5'h08, d); check("R1 ctl1", d, 32'h0108);
    check("R1 irq", {31'h0, irq}, 0);
    check("R1 sclk", {31'h0, sclk}, 0);

    // R2/R3: fill past depth in configuration mode
    setCfg(2, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    for (int i = 1; i <= 5; i++) busWrite(5'h18, i * 32'h11);
    busRead(5'h14, d); check("R2 tx fill capped", txFill(d), 4);
    check("R2 tx empty flag clear", {31'h0, d[15]}, 0);
    repeat (60) @(posedge clk);
    busRead(5'h14, d); check("R3 config holds words", txFill(d), 4);
    check("R13 not idle with queued words", {31'h0, d[2]}, 0);
    busWrite(5'h00, 32'h80);
    waitIdle();
    busRead(5'h14, d); check("R4 rx fill after drain", rxFill(d), 4);
    check("R2 tx empty flag", {31'h0, d[15]}, 1);
    for (int i = 1; i <= 4; i++) begin
      busRead(5'h18, d); check("R4 loopback order", d, i * 32'h11);
    end
    check("R8 serial msb-first", (cap.size() == 4) ? {16'h0, cap[3]} : 32'hdead, 32'h44);

    // R4 stall on full receive queue
    for (int i = 0; i < 4; i++) busWrite(5'h18, 32'hA0 + i);
    waitIdle();
    busWrite(5'h18, 32'hB5);
    repeat (80) @(posedge clk);
    busRead(5'h14, d);
    check("R4 stall tx", txFill(d), 1);
    check("R4 stall rx", rxFill(d), 4);
    busRead(5'h18, d); check("R4 head word", d, 32'hA0);
    waitIdle();
    busRead(5'h14, d); check("R4 resumes", rxFill(d), 4);
    for (int i = 0; i < 4; i++) busRead(5'h18, d);
    check("R4 last word", d, 32'hB5);

    // R9 locked fields in active mode
    busWrite(5'h08, 32'h0510);
    busWrite(5'h04, 32'h7);
    busRead(5'h08, d); check("R9 ctl1 locked", d, 32'h0208);
    busRead(5'h04, d); check("R9 ctl0 locked", d, 32'h0);

    // R5 zero divider, R6 odd length
    busWrite(5'h00, 32'h40);
    busWrite(5'h08, 32'h0010);
    busRead(5'h08, d); check("R5 zero divider", d, 32'h0110);
    busWrite(5'h08, 32'h030C);
    busRead(5'h08, d); check("R6 length fallback", d, 32'h0308);

    // R11 clear strobe
    for (int i = 0; i < 3; i++) busWrite(5'h18, i);
    busRead(5'h14, d); check("R11 before clear", txFill(d), 3);
    busWrite(5'h00, 32'h41);
    busRead(5'h14, d); check("R11 cleared", d, 32'h8004);

    // R12 stop request
    busWrite(5'h00, 32'h82);
    busWrite(5'h18, 32'h5A);
    repeat (80) @(posedge clk);
    busRead(5'h14, d); check("R12 stopped", txFill(d), 1);
    check("R13 not idle while stopped", {31'h0, d[2]}, 0);
    busWrite(5'h00, 32'h80);
    waitIdle();
    busRead(5'h18, d); check("R12 released", d, 32'h5A);

    // R7 idle polarity
    setCfg(3, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    check("R7 idle high", {31'h0, sclk}, 1);

    // R10 receive threshold at level 2
    setCfg(1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1200);
    busWrite(5'h00, 32'h80);
    busWrite(5'h18, 32'h1); waitIdle();
    busRead(5'h14, d); check("R10 below level flag", {31'h0, d[14]}, 0);
    check("R10 below level irq", {31'h0, irq}, 0);
    busWrite(5'h18, 32'h2); waitIdle();
    busRead(5'h14, d); check("R10 at level flag", {31'h0, d[14]}, 1);
    check("R10 at level irq", {31'h0, irq}, 1);
    busWrite(5'h04, 32'h1000);
    #1 check("R10 masked irq", {31'h0, irq}, 0);
    busRead(5'h14, d); check("R10 flag kept", {31'h0, d[14]}, 1);
    busWrite(5'h04, 32'h1200);
    busRead(5'h18, d);
    #1 check("R10 irq after pop", {31'h0, irq}, 0);
    busRead(5'h14, d); check("R10 flag after pop", {31'h0, d[14]}, 0);
    busRead(5'h18, d);

    // constrained random: R5 R6 R7 R8 under all modes
    for (int it = 0; it < 24; it++) begin
      int n;
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < 4; i++) w[i] = 16'($urandom);
      setCfg(1 + int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 0);
      check("R7 idle level", {31'h0, sclk}, {31'h0, monCpol});
      runBatch("rand", n, w);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule